// File: doc/BRIEF.md
# General-Purpose Pin Data and Direction Register File

This block holds the configuration and output state for fifty general-purpose pins behind a 16-bit register interface with byte offsets. Pins 0 to 31 are bidirectional. Each has a direction bit and a data bit, spread over a low and a high half-word. Pins 32 to 47 are output-only port pins, always driven from one data half-word. Pins 48 and 49 share a single half-word: its two low bits carry their data and bits 8 and 9 carry their output enables. The lowest fifteen pins also have pull resistor control. One register enables the pull, and a second register picks between pull-up and pull-down.

Software writes with a single-cycle strobe and reads with a single-cycle strobe. Read data is registered and appears one clock after the read strobe. A read of a data bit returns one of two values. If the pin is configured as an output, it returns the value being driven. If the pin is an input, it returns the pad level after a two-stage synchroniser. The reset input is asserted asynchronously and released through a two-flop synchroniser.

Top module: `gpio_regfile`

## Requirements
- R1: While reset is asserted, every register is zero and `rdata` is zero. Pins 0-31, 48 and 49 are then inputs (`pad_oe` low), all pulls are disabled, and `pad_out` is zero. Pins 32-47 always have `pad_oe` high.
- R2: The direction half-words at offsets 0x000 (pins 0-15) and 0x002 (pins 16-31) drive `pad_oe` bit for bit, where 1 means output. The new value is visible the cycle after the write.
- R3: The data half-words at 0x004 (pins 0-15) and 0x006 (pins 16-31) drive `pad_out` for those pins. The half-word at 0x01C drives `pad_out[47:32]`.
- R4: At offset 0x01E, bits 1:0 drive `pad_out[49:48]` and bits 9:8 drive `pad_oe[49:48]`. Every other bit of this half-word reads as zero.
- R5: A data-bit read for a pin configured as an output returns the driven value. Offset 0x01C always returns its stored value.
- R6: A data-bit read for an input pin returns the pad level sampled by two synchroniser flops. A pad change made before two clock edges have passed is visible to a read strobed after them. `rdata` changes only in the cycle after a read strobe.
- R7: The pull-enable half-word at 0x1E0 and the pull-select half-word at 0x1E2 cover pins 0-14. Bit 15 of both reads as zero. `pull_en` equals the enable bits. `pull_up` equals enable AND select. `pull_dn` equals enable AND NOT select, so a cleared enable bit turns both pulls off whatever the select bit holds.
- R8: Any other offset, including odd offsets, reads as zero. A write to such an offset changes no output.
- R9: A read and a write to the same offset in the same cycle return the value held before the write. The written value is returned by later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 9 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| pad_in | input | 50 | Pad input levels, asynchronous to `clk` |
| pad_out | output | 50 | Per-pin output value |
| pad_oe | output | 50 | Per-pin output enable |
| pull_en | output | 15 | Pull resistor enable, pins 0-14 |
| pull_up | output | 15 | Pull-up active, pins 0-14 |
| pull_dn | output | 15 | Pull-down active, pins 0-14 |

## Verification
A register write and a read of the same offset can land in the same clock cycle. The bench provokes this by raising both strobes together on the direction half-word after it holds a known pattern. The read result must equal the pattern stored before the write. A second plain read must then return the newly written value, which shows the write was neither lost nor merged into the concurrent read. The read mux is also exercised while pad inputs and direction bits are both non-trivial, so that the per-bit choice between driven and sampled levels is judged on mixed patterns.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 9;
  localparam int unsigned NUM_PINS  = 50;
  localparam int unsigned BIDIR_N   = 32;
  localparam int unsigned PULL_N    = 15;
  localparam int unsigned HI_N      = 2;
  localparam int unsigned SYNC_W    = BIDIR_N + HI_N;
  localparam int unsigned SYNC_STG  = 2;
  localparam int unsigned HI_OE_LSB = 8;

  localparam logic [ADDR_W-1:0] OFF_DIR_LO  = 9'h000;
  localparam logic [ADDR_W-1:0] OFF_DIR_HI  = 9'h002;
  localparam logic [ADDR_W-1:0] OFF_DAT_LO  = 9'h004;
  localparam logic [ADDR_W-1:0] OFF_DAT_HI  = 9'h006;
  localparam logic [ADDR_W-1:0] OFF_PORT_LO = 9'h01C;
  localparam logic [ADDR_W-1:0] OFF_PORT_HI = 9'h01E;
  localparam logic [ADDR_W-1:0] OFF_PULL_EN = 9'h1E0;
  localparam logic [ADDR_W-1:0] OFF_PULL_UP = 9'h1E2;

  typedef struct packed {
    logic [DATA_W-1:0] dir_lo;
    logic [DATA_W-1:0] dir_hi;
    logic [DATA_W-1:0] dat_lo;
    logic [DATA_W-1:0] dat_hi;
    logic [DATA_W-1:0] port_lo;
    logic [HI_N-1:0]   hi_dat;
    logic [HI_N-1:0]   hi_oe;
    logic [PULL_N-1:0] pull_use;
    logic [PULL_N-1:0] pull_sel;
  } gpio_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output gpio_cfg_t         cfg
);

  gpio_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    case (addr)
      OFF_DIR_LO:  cfg_d.dir_lo  = wdata;
      OFF_DIR_HI:  cfg_d.dir_hi  = wdata;
      OFF_DAT_LO:  cfg_d.dat_lo  = wdata;
      OFF_DAT_HI:  cfg_d.dat_hi  = wdata;
      OFF_PORT_LO: cfg_d.port_lo = wdata;
      OFF_PORT_HI: begin
        cfg_d.hi_dat = wdata[HI_N-1:0];
        cfg_d.hi_oe  = wdata[HI_OE_LSB +: HI_N];
      end
      OFF_PULL_EN: cfg_d.pull_use = wdata[PULL_N-1:0];
      OFF_PULL_UP: cfg_d.pull_sel = wdata[PULL_N-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  gpio_cfg_t         cfg,
  input  logic [SYNC_W-1:0] pad_sync,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HALF = BIDIR_N / 2;

  logic [DATA_W-1:0] rd_d, rd_q;
  logic [HI_N-1:0]   hi_lvl;

  always_comb begin
    hi_lvl = (cfg.hi_dat & cfg.hi_oe) | (pad_sync[BIDIR_N +: HI_N] & ~cfg.hi_oe);
    rd_d   = '0;
    case (addr)
      OFF_DIR_LO:  rd_d = cfg.dir_lo;
      OFF_DIR_HI:  rd_d = cfg.dir_hi;
      OFF_DAT_LO:  rd_d = (cfg.dat_lo & cfg.dir_lo) | (pad_sync[0 +: HALF] & ~cfg.dir_lo);
      OFF_DAT_HI:  rd_d = (cfg.dat_hi & cfg.dir_hi) | (pad_sync[HALF +: HALF] & ~cfg.dir_hi);
      OFF_PORT_LO: rd_d = cfg.port_lo;
      OFF_PORT_HI: begin
        rd_d[HI_N-1:0]            = hi_lvl;
        rd_d[HI_OE_LSB +: HI_N]   = cfg.hi_oe;
      end
      OFF_PULL_EN: rd_d[PULL_N-1:0] = cfg.pull_use;
      OFF_PULL_UP: rd_d[PULL_N-1:0] = cfg.pull_sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [PULL_N-1:0]   pull_en,
  output logic [PULL_N-1:0]   pull_up,
  output logic [PULL_N-1:0]   pull_dn
);

  localparam int unsigned PORT_LSB = BIDIR_N;
  localparam int unsigned HI_LSB   = NUM_PINS - HI_N;

  logic [1:0]        rst_q;
  logic              rst_sync_n;
  gpio_cfg_t         cfg;
  logic [SYNC_W-1:0] pad_sel;
  logic [SYNC_W-1:0] pad_sync;
  logic              unused_port_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign pad_sel        = {pad_in[HI_LSB +: HI_N], pad_in[BIDIR_N-1:0]};
  assign unused_port_in = ^pad_in[HI_LSB-1:PORT_LSB];

  gpio_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_sel),
    .q     (pad_sync)
  );

  gpio_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cfg   (cfg)
  );

  gpio_rd_mux u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .cfg      (cfg),
    .pad_sync (pad_sync),
    .rdata    (rdata)
  );

  assign pad_out = {cfg.hi_dat, cfg.port_lo, cfg.dat_hi, cfg.dat_lo};
  assign pad_oe  = {cfg.hi_oe, {(HI_LSB-PORT_LSB){1'b1}}, cfg.dir_hi, cfg.dir_lo};
  assign pull_en = cfg.pull_use;
  assign pull_up = cfg.pull_use & cfg.pull_sel;
  assign pull_dn = cfg.pull_use & ~cfg.pull_sel;

endmodule

// File: rtl/gpio_regfile_chk.sv
module gpio_regfile_chk
  import gpio_pkg::*;
(
  input logic                clk,
  input logic                rst_ni,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [PULL_N-1:0]   pull_en,
  input logic [PULL_N-1:0]   pull_up,
  input logic [PULL_N-1:0]   pull_dn
);

  logic mapped;
  assign mapped = (addr == OFF_DIR_LO)  || (addr == OFF_DIR_HI)  ||
                  (addr == OFF_DAT_LO)  || (addr == OFF_DAT_HI)  ||
                  (addr == OFF_PORT_LO) || (addr == OFF_PORT_HI) ||
                  (addr == OFF_PULL_EN) || (addr == OFF_PULL_UP);

  p_dir_lo_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == OFF_DIR_LO) |=> pad_oe[15:0] == $past(wdata));

  p_hi_oe_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == OFF_PORT_HI) |=> pad_oe[49:48] == $past(wdata[9:8]));

  p_pull_excl_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pull_up & pull_dn) == '0) && ((pull_up | pull_dn) == pull_en));

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !mapped) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pull_en)));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_regfile gpio_regfile_chk u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .pull_en (pull_en),
  .pull_up (pull_up),
  .pull_dn (pull_dn)
);

// File: tb/gpio_regfile_tb.sv
module gpio_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [49:0] pad_in = '0;
  logic [49:0] pad_out, pad_oe;
  logic [14:0] pull_en, pull_up, pull_dn;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .pull_up(pull_up), .pull_dn(pull_dn)
  );

  // {offset, write value, expected readback}; pad_in is zero while walked
  localparam logic [40:0] VEC [11] = '{
    {9'h000, 16'hA5A5, 16'hA5A5},  // R2
    {9'h002, 16'hFFFF, 16'hFFFF},  // R2
    {9'h004, 16'hFFFF, 16'hA5A5},  // R3 R5 R6 output bits driven, inputs see 0
    {9'h006, 16'h1234, 16'h1234},  // R3 R5
    {9'h01C, 16'hBEEF, 16'hBEEF},  // R3 R5
    {9'h01E, 16'hFFFF, 16'h0303},  // R4
    {9'h1E0, 16'hFFFF, 16'h7FFF},  // R7
    {9'h1E2, 16'h00F0, 16'h00F0},  // R7
    {9'h008, 16'hFFFF, 16'h0000},  // R8
    {9'h001, 16'hFFFF, 16'h0000},  // R8
    {9'h1E4, 16'hFFFF, 16'h0000}   // R8
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", 64'(rdata), 64'h0);
    check("R1 pad_oe", 64'(pad_oe), 64'h0000_FFFF_0000_0000);
    check("R1 pad_out", 64'(pad_out), 64'h0);
    check("R1 pull_en", 64'(pull_en), 64'h0);
    check("R1 pull_up/dn", 64'({pull_up, pull_dn}), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      do_write(VEC[i][40:32], VEC[i][31:16]);
      do_read(VEC[i][40:32], rd);
      check($sformatf("R2-R8 vec%0d off %h", i, VEC[i][40:32]), 64'(rd), 64'(VEC[i][15:0]));
    end

    // outputs after table; the unmapped writes at the end must not disturb them (R8)
    check("R2 R8 pad_oe", 64'(pad_oe), 64'h0003_FFFF_FFFF_A5A5);
    check("R3 R8 pad_out", 64'(pad_out), 64'h0003_BEEF_1234_FFFF);
    check("R7 pull_en", 64'(pull_en), 64'h7FFF);
    check("R7 pull_up", 64'(pull_up), 64'h00F0);
    check("R7 pull_dn", 64'(pull_dn), 64'h7F0F);

    // R6 input pins see synchronised pad levels
    @(negedge clk);
    pad_in[15:0] = 16'h0F0F;
    @(negedge clk);
    do_read(9'h004, rd);
    check("R6 R5 mixed dat_lo", 64'(rd), 64'hAFAF);

    // R4 pins 48/49 as inputs
    do_write(9'h01E, 16'h0001);
    check("R4 oe48/49 off", 64'(pad_oe[49:48]), 64'h0);
    check("R4 out48/49", 64'(pad_out[49:48]), 64'h1);
    @(negedge clk);
    pad_in[49:48] = 2'b10;
    @(negedge clk);
    do_read(9'h01E, rd);
    check("R4 R6 port_hi input read", 64'(rd), 64'h0002);

    // R7 clearing enable kills both pulls
    do_write(9'h1E0, 16'h0000);
    check("R7 pull_up off", 64'(pull_up), 64'h0);
    check("R7 pull_dn off", 64'(pull_dn), 64'h0);

    // R9 simultaneous read and write on the same offset
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 9'h000; wdata = 16'h1111;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 old value on collision", 64'(rdata), 64'hA5A5);
    do_read(9'h000, rd);
    check("R9 new value after", 64'(rd), 64'h1111);
    check("R2 pad_oe after collision", 64'(pad_oe[15:0]), 64'h1111);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule